// File: doc/BRIEF.md
# I2C Target with Alternating Register-Pair Readback

This block is the serial front end of a 16-bit general-purpose port device. It listens on a two-wire I2C bus and answers one 7-bit target address. The upper four bits of that address are fixed and the lower three come from board strap inputs. A master first addresses the target for writing and sends a command byte that names one of eight registers. It then issues a repeated START, addresses the target again for reading, and clocks out data bytes.

The first byte read back is the register that the command named. Every further byte that the master acknowledges comes from the other register of the same pair. The pair is the two registers whose selector values differ only in bit 0. Reading therefore alternates between the two registers for as long as the master keeps acknowledging. The block never steps through the wider register map.

The block samples SCL and SDA with the system clock. It drives SDA only through an open-drain enable. It reads register contents through a small combinational read port: it presents a selector, and the surrounding register file returns the byte.

Top module: `i2c_pair_reader`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits equal 0100 followed by strap bits 2, 1 and 0. It does this by driving SDA low during the ninth clock. Any other address gets no acknowledge, and the rest of that transaction, including further bytes, is not acknowledged.
- R2: A command byte received after a write address (bit 0 of the address byte = 0) is acknowledged. Its low three bits become the register selector `reg_sel_o`, and its upper five bits are discarded. Data bytes that follow the command in the same write are not acknowledged.
- R3: After a repeated START and a read address (bit 0 = 1), the first byte returned is the selected register, sent most significant bit first.
- R4: Each byte after one that the master acknowledged comes from the partner register, with selector bit 0 inverted. The alternation continues for any number of bytes, and selector bits 2..1 never change during a read.
- R5: When the master does not acknowledge a byte, the target releases SDA. It then drives nothing further until a new START arrives.
- R6: A STOP in any phase returns the target to idle with SDA released, and a START always restarts address reception.
- R7: The selected register survives a STOP. A read with no new command byte starts from the last commanded register.
- R8: `sda_oe_o` changes only while SCL is low.
- R9: After reset, `sda_oe_o` is 0 and `reg_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Board straps giving the low three address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_sel_o | output | 3 | Register selector for the read port |
| reg_data_i | input | 8 | Contents of the register named by `reg_sel_o` |

## Verification
Two events share a single SCL falling edge. When a command byte completes, the selector is captured on the same edge that starts the acknowledge drive. When a master acknowledge completes, the next byte is fetched through the read port on the same edge that drives its first bit, and this relies on the pointer having flipped earlier in that ninth clock. The bench runs every command value, including ones with nonzero upper bits. It checks the acknowledge and the selector right after the command, then checks each byte of a five-byte burst against the arithmetic register model, so a late flip or a late fetch would return the wrong register's byte. A STOP issued while the target holds its first data bit high checks that the abort and a released data line coincide.

// File: rtl/i2c_pr_pkg.sv
package i2c_pr_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int STRAP_W  = 3;
    localparam int SEL_W    = 3;
    localparam int FIXED_W  = ADDR_W - STRAP_W;
    localparam int CNT_W    = $clog2(BYTE_W + 1);

    localparam logic [FIXED_W-1:0] ADDR_FIXED = 4'b0100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_TX,
        ST_TX_ACK
    } phase_e;

    typedef enum logic [1:0] {
        SH_HOLD,
        SH_IN,
        SH_OUT,
        SH_LOAD
    } sh_op_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_match(input logic [BYTE_W-1:0] frame,
                                        input logic [STRAP_W-1:0] strap);
        return frame[BYTE_W-1:1] == {ADDR_FIXED, strap};
    endfunction

endpackage

// File: rtl/i2c_pr_sync.sv
module i2c_pr_sync
    import i2c_pr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_st;
    logic [STAGES-1:0] sda_st;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_st <= '1;
            sda_st <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_st[0] <= scl_i;
            sda_st[0] <= sda_i;
            for (int i = 1; i < STAGES; i++) begin
                scl_st[i] <= scl_st[i-1];
                sda_st[i] <= sda_st[i-1];
            end
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s = scl_st[STAGES-1];
    assign sda_s = sda_st[STAGES-1];

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/i2c_pr_shreg.sv
module i2c_pr_shreg
    import i2c_pr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  sh_op_e       op,
    input  logic         sin,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                SH_IN:   q <= {q[W-2:0], sin};
                SH_OUT:  q <= {q[W-2:0], 1'b0};
                SH_LOAD: q <= load_val;
                default: q <= q;
            endcase
        end
    end

endmodule

// File: rtl/i2c_pr_pointer.sv
module i2c_pr_pointer #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [SEL_W-1:0] cmd_val,
    input  logic             flip_clr,
    input  logic             flip_tgl,
    output logic [SEL_W-1:0] sel
);

    logic [SEL_W-1:0] cmd_q;
    logic             flip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            flip_q <= 1'b0;
        end else if (cmd_wr) begin
            cmd_q  <= cmd_val;
            flip_q <= 1'b0;
        end else if (flip_clr) begin
            flip_q <= 1'b0;
        end else if (flip_tgl) begin
            flip_q <= ~flip_q;
        end
    end

    assign sel = {cmd_q[SEL_W-1:1], cmd_q[0] ^ flip_q};

endmodule

// File: rtl/i2c_pair_reader.sv
module i2c_pair_reader
    import i2c_pr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o,
    output logic [SEL_W-1:0]   reg_sel_o,
    input  logic [BYTE_W-1:0]  reg_data_i
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    bus_ev_t           ev;
    logic              start_det;
    logic              stop_det;
    phase_e            phase_q, phase_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              oe_q, oe_d;
    logic              rw_q, rw_d;
    logic              mack_q, mack_d;
    sh_op_e            sh_op;
    logic [BYTE_W-1:0] sh_q;
    logic              cmd_wr;
    logic              flip_clr;
    logic              flip_tgl;

    i2c_pr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign start_det = ev.start;
    assign stop_det  = ev.stop;

    i2c_pr_shreg #(.W(BYTE_W)) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .op       (sh_op),
        .sin      (ev.sda),
        .load_val (reg_data_i),
        .q        (sh_q)
    );

    i2c_pr_pointer #(.SEL_W(SEL_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_val  (sh_q[SEL_W-1:0]),
        .flip_clr (flip_clr),
        .flip_tgl (flip_tgl),
        .sel      (reg_sel_o)
    );

    always_comb begin
        phase_d  = phase_q;
        cnt_d    = cnt_q;
        oe_d     = oe_q;
        rw_d     = rw_q;
        mack_d   = mack_q;
        sh_op    = SH_HOLD;
        cmd_wr   = 1'b0;
        flip_clr = 1'b0;
        flip_tgl = 1'b0;

        if (stop_det) begin
            phase_d = ST_IDLE;
            oe_d    = 1'b0;
        end else if (start_det) begin
            phase_d = ST_ADDR;
            cnt_d   = '0;
            oe_d    = 1'b0;
        end else begin
            unique case (phase_q)
                ST_IDLE: begin
                    oe_d = 1'b0;
                end
                ST_ADDR, ST_CMD: begin
                    if (ev.scl_rise && cnt_q != CNT_FULL) begin
                        sh_op = SH_IN;
                        cnt_d = cnt_q + 1'b1;
                    end else if (ev.scl_fall && cnt_q == CNT_FULL) begin
                        if (phase_q == ST_ADDR) begin
                            if (addr_match(sh_q, strap_i)) begin
                                oe_d     = 1'b1;
                                rw_d     = sh_q[0];
                                flip_clr = sh_q[0];
                                phase_d  = ST_ADDR_ACK;
                            end else begin
                                phase_d = ST_IDLE;
                            end
                        end else begin
                            cmd_wr  = 1'b1;
                            oe_d    = 1'b1;
                            phase_d = ST_CMD_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        cnt_d = '0;
                        if (rw_q) begin
                            sh_op   = SH_LOAD;
                            oe_d    = ~reg_data_i[BYTE_W-1];
                            phase_d = ST_TX;
                        end else begin
                            oe_d    = 1'b0;
                            phase_d = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK: begin
                    if (ev.scl_fall) begin
                        oe_d    = 1'b0;
                        phase_d = ST_IDLE;
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt_q == CNT_LAST) begin
                            oe_d    = 1'b0;
                            mack_d  = 1'b0;
                            phase_d = ST_TX_ACK;
                        end else begin
                            sh_op = SH_OUT;
                            oe_d  = ~sh_q[BYTE_W-2];
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise) begin
                        mack_d   = ~ev.sda;
                        flip_tgl = ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack_q) begin
                            sh_op   = SH_LOAD;
                            oe_d    = ~reg_data_i[BYTE_W-1];
                            cnt_d   = '0;
                            phase_d = ST_TX;
                        end else begin
                            phase_d = ST_IDLE;
                        end
                    end
                end
                default: begin
                    phase_d = ST_IDLE;
                    oe_d    = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_IDLE;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            oe_q    <= oe_d;
            rw_q    <= rw_d;
            mack_q  <= mack_d;
        end
    end

    assign sda_oe_o = oe_q;

endmodule

// File: rtl/i2c_pr_checker.sv
module i2c_pr_checker
    import i2c_pr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             scl_i,
    input logic             sda_oe,
    input logic [SEL_W-1:0] reg_sel,
    input phase_e           phase,
    input logic             start_det,
    input logic             stop_det,
    input logic             cmd_wr
);

    p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    p_stop_release_r6: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe && phase == ST_IDLE);

    p_start_restart_r6: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe && phase == ST_ADDR);

    p_pair_only_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_sel != $past(reg_sel) && !$past(cmd_wr))
            |-> reg_sel[SEL_W-1:1] == $past(reg_sel[SEL_W-1:1]));

    p_sel_hold_tx_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_TX) |-> $stable(reg_sel));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IDLE && !start_det) |=> !sda_oe);

endmodule

bind i2c_pair_reader i2c_pr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe_o),
    .reg_sel   (reg_sel_o),
    .phase     (phase_q),
    .start_det (start_det),
    .stop_det  (stop_det),
    .cmd_wr    (cmd_wr)
);

// File: tb/i2c_pair_reader_bench.sv
`timescale 1ns/1ps
module i2c_pair_reader_bench;

    localparam int Q = 5;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'd0;
    logic       sda_oe;
    logic [2:0] reg_sel;
    logic [7:0] reg_data;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    int r8_viol = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] reg_val(input logic [2:0] a);
        return 8'((32'(a) * 53) ^ 32'hC6);
    endfunction

    assign reg_data = reg_val(reg_sel);
    assign sda_line = m_sda & ~sda_oe;

    i2c_pair_reader u_i2c_pair_reader (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .strap_i    (strap),
        .sda_oe_o   (sda_oe),
        .reg_sel_o  (reg_sel),
        .reg_data_i (reg_data)
    );

    // R8 monitor: output enable may move only while the clock line is low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_oe !== oe_prev && m_scl) r8_viol++;
        oe_prev <= sda_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bit_out(input logic b);
        wt(Q); m_sda = b; wt(Q); m_scl = 1'b1; wt(H); m_scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        wt(Q); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); b = sda_line; wt(Q); m_scl = 1'b0;
    endtask

    task automatic bus_start();
        wt(Q); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_in(b);
            v[i] = b;
        end
        bit_out(~give_ack);
    endtask

    initial begin
        logic       ack;
        logic [7:0] d;
        logic [7:0] aw;
        logic [7:0] ar;

        wt(4);
        // R9 reset state
        check(sda_oe == 1'b0, "R9 sda_oe after reset", int'(sda_oe), 0);
        check(reg_sel == 3'd0, "R9 reg_sel after reset", int'(reg_sel), 0);
        rst = 1'b0;
        wt(4);

        // R1 address sweep over every strap and every low address value
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            for (int a = 0; a < 8; a++) begin
                bus_start();
                send_byte({4'b0100, 3'(a), 1'b0}, ack);
                check(ack == (a == s), "R1 address match", int'(ack), int'(a == s));
                bus_stop();
            end
            bus_start();
            send_byte({4'b0110, 3'(s), 1'b0}, ack);
            check(ack == 1'b0, "R1 wrong fixed bits", int'(ack), 0);
            bus_stop();
        end

        strap = 3'd5;
        aw = {4'b0100, 3'd5, 1'b0};
        ar = {4'b0100, 3'd5, 1'b1};

        // R1 non-matching address: rest of the transaction is ignored
        bus_start();
        send_byte({4'b0100, 3'd2, 1'b0}, ack);
        check(ack == 1'b0, "R1 foreign address", int'(ack), 0);
        send_byte(8'h03, ack);
        check(ack == 1'b0, "R1 following byte ignored", int'(ack), 0);
        check(reg_sel == 3'd0, "R1 selector untouched", int'(reg_sel), 0);
        bus_stop();

        // R2/R3/R4/R5 sweep over all commands, upper bits nonzero
        for (int k = 0; k < 8; k++) begin
            logic [7:0] cmd;
            cmd = {5'(k * 5 + 3), 3'(k)};
            bus_start();
            send_byte(aw, ack);
            check(ack == 1'b1, "R1 write address ack", int'(ack), 1);
            send_byte(cmd, ack);
            check(ack == 1'b1, "R2 command ack", int'(ack), 1);
            check(reg_sel == 3'(k), "R2 command truncated to selector", int'(reg_sel), k);
            bus_start();
            send_byte(ar, ack);
            check(ack == 1'b1, "R1 read address ack", int'(ack), 1);
            for (int i = 0; i < 5; i++) begin
                logic [7:0] ex;
                ex = reg_val(3'(k) ^ 3'(i & 1));
                recv_byte(i != 4, d);
                if (i == 0) check(d == ex, "R3 first byte", int'(d), int'(ex));
                else        check(d == ex, "R4 alternating byte", int'(d), int'(ex));
            end
            wt(2);
            check(sda_oe == 1'b0, "R5 release after NACK", int'(sda_oe), 0);
            recv_byte(1'b0, d);
            check(d == 8'hFF, "R5 silent after NACK", int'(d), 8'hFF);
            bus_stop();
        end

        // R2 data bytes after the command are not acknowledged
        bus_start();
        send_byte(aw, ack);
        send_byte(8'h02, ack);
        send_byte(8'h5A, ack);
        check(ack == 1'b0, "R2 write data not acked", int'(ack), 0);
        bus_stop();

        // R7 selector kept across STOP, read without a command
        bus_start();
        send_byte(ar, ack);
        check(ack == 1'b1, "R7 read address ack", int'(ack), 1);
        recv_byte(1'b1, d);
        check(d == reg_val(3'd2), "R7 first byte from kept selector", int'(d), int'(reg_val(3'd2)));
        recv_byte(1'b0, d);
        check(d == reg_val(3'd3), "R7 partner byte", int'(d), int'(reg_val(3'd3)));
        bus_stop();

        // R6 STOP in the middle of an address byte
        bus_start();
        for (int i = 0; i < 4; i++) bit_out(aw[7 - i]);
        bus_stop();
        check(sda_oe == 1'b0, "R6 released after address abort", int'(sda_oe), 0);
        bus_start();
        send_byte(aw, ack);
        check(ack == 1'b1, "R6 fresh transaction after abort", int'(ack), 1);
        send_byte(8'h00, ack);
        bus_stop();

        // R6 STOP while the target presents a high first data bit
        bus_start();
        send_byte(ar, ack);
        wt(Q);
        check(sda_oe == 1'b0, "R6 first bit of reg 0 is high", int'(sda_oe), 0);
        bus_stop();
        wt(2);
        check(sda_oe == 1'b0, "R6 released after read abort", int'(sda_oe), 0);
        recv_byte(1'b0, d);
        check(d == 8'hFF, "R6 idle after read abort", int'(d), 8'hFF);
        bus_start();
        send_byte(ar, ack);
        recv_byte(1'b0, d);
        check(d == reg_val(3'd0), "R6 read restarts cleanly", int'(d), int'(reg_val(3'd0)));
        bus_stop();

        check(r8_viol == 0, "R8 enable moved with clock high", r8_viol, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule